// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block produces the instruction address sequence for a 32-bit RISC core with one architectural delay slot. It holds three registered addresses: the address of the instruction now executing (`pc_o`), the address of its delay-slot successor (`npc_o`) and the address after that (`nnpc_o`). The decode stage supplies a resolved control-transfer kind, the condition result, the branch offset, the jump index and a register operand. It also sets a strobe on each cycle in which the executing instruction retires. On each strobe the sequencer shifts the triple forward, with any control transfer applied.

Transfers take effect one instruction late, so the delay-slot instruction always runs. The exception is a not-taken likely branch. That case skips the slot, and the sequencer raises an annul flag so the pipeline squashes the slot instruction it has already fetched. A transfer that links reports a return-address write with the address that follows the delay slot. A register jump to an address that is not word-aligned is refused and flagged. All pins are plain control and status signals. The strobe is a one-way advance and has no back-pressure.

Top module: `dslot_pc_seq`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `pc_o` = `RESET_VEC` (default 32'hBFC0_0000), `npc_o` = `RESET_VEC`+4 and `nnpc_o` = `RESET_VEC`+8. `link_we_o`, `annul_o` and `misalign_o` are 0.
- R2: On an ordinary advance, `pc_o` takes the old `npc_o`, `npc_o` takes the resolved successor and `nnpc_o` takes that value plus 4. Without `step_i`, no output address and no annul state changes.
- R3: A taken branch sets the new `npc_o` to the old `npc_o` plus the offset shifted left by 2 and sign-extended from bit 17.
- R4: A conditional branch (kind 1) with `cond_i`=0 continues sequentially.
- R5: An unconditional branch (kind 3) is taken whatever the value of `cond_i`.
- R6: A likely branch (kind 2) with `cond_i`=1 behaves as a taken branch. With `cond_i`=0 it skips the slot: `pc_o` takes the old `nnpc_o`, `npc_o` the old `nnpc_o`+4 and `nnpc_o` the old `nnpc_o`+8. `annul_o` then rises and stays high until the next advance.
- R7: A direct jump (kind 4) sets the new `npc_o` to the upper 4 bits of the old `npc_o` concatenated with `index_i` and two zero bits.
- R8: A register jump (kind 5) sets the new `npc_o` to `reg_val_i`, whatever the value of `cond_i`.
- R9: A register jump whose `reg_val_i[1:0]` is non-zero leaves all three addresses and `annul_o` unchanged. It pulses `misalign_o` for one cycle and raises no link write.
- R10: A transfer of kind 1 to 5 with `link_i`=1 pulses `link_we_o` for one cycle, whether or not the branch is taken. `link_data_o` then carries the `nnpc_o` value from before the advance.
- R11: Kind encoding on `kind_i`: 0 sequential, 1 conditional branch, 2 likely branch, 3 unconditional branch, 4 direct jump, 5 register jump. Codes 6 and 7 act as sequential. `link_i` has no effect on sequential kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance strobe, one per retiring instruction |
| kind_i | input | 3 | Control-transfer kind of the instruction at `pc_o` |
| link_i | input | 1 | Transfer writes the return address |
| cond_i | input | 1 | Resolved branch condition |
| offset_i | input | 16 | Branch word offset |
| index_i | input | 26 | Direct jump word index |
| reg_val_i | input | 32 | Register jump target |
| pc_o | output | 32 | Executing address |
| npc_o | output | 32 | Delay-slot address |
| nnpc_o | output | 32 | Address after the delay slot |
| link_we_o | output | 1 | Return-address write pulse |
| link_data_o | output | 32 | Return address |
| annul_o | output | 1 | Squash the fetched delay-slot instruction |
| misalign_o | output | 1 | Register jump target not word-aligned, pulse |

## Verification
Two functions can fire on one advance. A not-taken likely branch that links must skip the slot, raise the annul flag and also write a return address. That address must be the `nnpc_o` from before the skip, not the one after it. The vector table drives this combination from a state reached by a register jump, and separately from reset. In each case the three addresses, the annul flag, the link pulse and the link data are compared in the same sample. A second collision, a linking register jump to a misaligned target, must report the error and suppress the link in the same cycle.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  typedef enum logic [2:0] {
    XF_SEQ  = 3'd0,
    XF_BR   = 3'd1,
    XF_BRL  = 3'd2,
    XF_BRA  = 3'd3,
    XF_JD   = 3'd4,
    XF_JR   = 3'd5,
    XF_RSV6 = 3'd6,
    XF_RSV7 = 3'd7
  } xfer_e;

  typedef struct packed {
    logic adv;    // state moves this cycle
    logic skip;   // likely branch not taken: jump over slot
    logic link;   // return address write
    logic misal;  // refused register jump
  } step_ctl_t;

  function automatic logic is_transfer(xfer_e k);
    return (k == XF_BR) || (k == XF_BRL) || (k == XF_BRA) ||
           (k == XF_JD) || (k == XF_JR);
  endfunction

endpackage

// File: rtl/dsq_target.sv
module dsq_target #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 26
) (
  input  logic [ADDR_W-1:0] npc,
  input  logic [OFF_W-1:0]  offset,
  input  logic [IDX_W-1:0]  index,
  output logic [ADDR_W-1:0] br_tgt,
  output logic [ADDR_W-1:0] jd_tgt
);
  localparam int DISP_W = OFF_W + 2;
  localparam int EXT_W  = ADDR_W - DISP_W;
  localparam int REG_W  = ADDR_W - IDX_W - 2;

  logic [ADDR_W-1:0] disp;

  // byte displacement, sign taken from the top offset bit
  assign disp   = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
  assign br_tgt = npc + disp;

  generate
    if (REG_W > 0) begin : g_region
      assign jd_tgt = {npc[ADDR_W-1 -: REG_W], index, 2'b00};
    end else begin : g_flat
      assign jd_tgt = {index[ADDR_W-3:0], 2'b00};
    end
  endgenerate

endmodule

// File: rtl/dsq_resolve.sv
module dsq_resolve
  import dsq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              step,
  input  xfer_e             kind,
  input  logic              cond,
  input  logic              link_req,
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [ADDR_W-1:0] br_tgt,
  input  logic [ADDR_W-1:0] jd_tgt,
  input  logic [ADDR_W-1:0] nnpc,
  output logic [ADDR_W-1:0] succ,
  output step_ctl_t         ctl
);
  logic taken;
  logic bad_align;

  always_comb begin
    unique case (kind)
      XF_BR, XF_BRL: taken = cond;
      XF_BRA:        taken = 1'b1;
      default:       taken = 1'b0;
    endcase
  end

  always_comb begin
    case (kind)
      XF_BR, XF_BRL, XF_BRA: succ = taken ? br_tgt : nnpc;
      XF_JD:                 succ = jd_tgt;
      XF_JR:                 succ = reg_val;
      default:               succ = nnpc;
    endcase
  end

  assign bad_align = (kind == XF_JR) && (reg_val[1:0] != 2'b00);

  always_comb begin
    ctl.adv   = step && !bad_align;
    ctl.skip  = step && (kind == XF_BRL) && !cond;
    ctl.misal = step && bad_align;
    ctl.link  = step && link_req && is_transfer(kind) && !bad_align;
  end

endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
  import dsq_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          OFF_W     = 16,
  parameter int          IDX_W     = 26,
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [2:0]        kind_i,
  input  logic              link_i,
  input  logic              cond_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic [ADDR_W-1:0] reg_val_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] npc_o,
  output logic [ADDR_W-1:0] nnpc_o,
  output logic              link_we_o,
  output logic [ADDR_W-1:0] link_data_o,
  output logic              annul_o,
  output logic              misalign_o
);
  localparam logic [ADDR_W-1:0] WORD  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] VEC0  = ADDR_W'(RESET_VEC);

  logic [ADDR_W-1:0] pc_q, npc_q, nnpc_q, link_data_q;
  logic              link_we_q, annul_q, misal_q;
  logic [ADDR_W-1:0] br_tgt, jd_tgt, succ;
  step_ctl_t         ctl;
  xfer_e             kind;

  assign kind = xfer_e'(kind_i);

  dsq_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
    .npc    (npc_q),
    .offset (offset_i),
    .index  (index_i),
    .br_tgt (br_tgt),
    .jd_tgt (jd_tgt)
  );

  dsq_resolve #(.ADDR_W(ADDR_W)) u_res (
    .step     (step_i),
    .kind     (kind),
    .cond     (cond_i),
    .link_req (link_i),
    .reg_val  (reg_val_i),
    .br_tgt   (br_tgt),
    .jd_tgt   (jd_tgt),
    .nnpc     (nnpc_q),
    .succ     (succ),
    .ctl      (ctl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= VEC0;
      npc_q   <= VEC0 + WORD;
      nnpc_q  <= VEC0 + WORD + WORD;
      annul_q <= 1'b0;
    end else if (ctl.adv) begin
      annul_q <= ctl.skip;
      if (ctl.skip) begin
        pc_q   <= nnpc_q;
        npc_q  <= nnpc_q + WORD;
        nnpc_q <= nnpc_q + WORD + WORD;
      end else begin
        pc_q   <= npc_q;
        npc_q  <= succ;
        nnpc_q <= succ + WORD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_we_q   <= 1'b0;
      link_data_q <= '0;
      misal_q     <= 1'b0;
    end else begin
      link_we_q <= ctl.link;
      misal_q   <= ctl.misal;
      if (ctl.link) link_data_q <= nnpc_q;
    end
  end

  assign pc_o        = pc_q;
  assign npc_o       = npc_q;
  assign nnpc_o      = nnpc_q;
  assign link_we_o   = link_we_q;
  assign link_data_o = link_data_q;
  assign annul_o     = annul_q;
  assign misalign_o  = misal_q;

  // R2
  triple_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nnpc_q == npc_q + WORD);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> ($stable(pc_q) && $stable(npc_q) && $stable(annul_q)));

  // R2
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.adv && !ctl.skip) |=> (pc_q == $past(npc_q) && !annul_q));

  // R6
  skip_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.adv && ctl.skip) |=> (pc_q == $past(nnpc_q) && annul_q));

  // R9
  misal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && kind == XF_JR && reg_val_i[1:0] != 2'b00)
      |=> ($stable(pc_q) && $stable(npc_q) && misal_q && !link_we_q));

  // R10
  link_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.link |=> (link_we_q && link_data_q == $past(nnpc_q)));

  // R10
  link_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_q |-> $past(step_i && link_i));

endmodule

// File: tb/sim_dslot_pc_seq.sv
module sim_dslot_pc_seq;

  typedef struct packed {
    logic [23:0] req;
    logic [2:0]  kind;
    logic        link;
    logic        cond;
    logic [15:0] off;
    logic [25:0] idx;
    logic [31:0] rv;
    logic [31:0] e_pc;
    logic [31:0] e_npc;
    logic [31:0] e_nnpc;
    logic        e_lwe;
    logic [31:0] e_ldata;
    logic        e_ann;
    logic        e_mis;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // R2 plain advance
    '{"R2 ", 3'd0, 1'b0, 1'b0, 16'h0000, 26'h0, 32'h0, 32'hBFC00004, 32'hBFC00008, 32'hBFC0000C, 1'b0, 32'h0, 1'b0, 1'b0},
    // R3 taken forward branch
    '{"R3 ", 3'd1, 1'b0, 1'b1, 16'h0010, 26'h0, 32'h0, 32'hBFC00008, 32'hBFC00048, 32'hBFC0004C, 1'b0, 32'h0, 1'b0, 1'b0},
    // R4 not taken with link (R10)
    '{"R4 ", 3'd1, 1'b1, 1'b0, 16'h0010, 26'h0, 32'h0, 32'hBFC00048, 32'hBFC0004C, 32'hBFC00050, 1'b1, 32'hBFC0004C, 1'b0, 1'b0},
    // R3 backward branch
    '{"R3 ", 3'd1, 1'b0, 1'b1, 16'hFFFE, 26'h0, 32'h0, 32'hBFC0004C, 32'hBFC00044, 32'hBFC00048, 1'b0, 32'h0, 1'b0, 1'b0},
    // R6 likely not taken
    '{"R6 ", 3'd2, 1'b0, 1'b0, 16'h0010, 26'h0, 32'h0, 32'hBFC00048, 32'hBFC0004C, 32'hBFC00050, 1'b0, 32'h0, 1'b1, 1'b0},
    // R6 likely taken
    '{"R6 ", 3'd2, 1'b0, 1'b1, 16'h0100, 26'h0, 32'h0, 32'hBFC0004C, 32'hBFC0044C, 32'hBFC00450, 1'b0, 32'h0, 1'b0, 1'b0},
    // R5 unconditional, cond low, most negative offset, link
    '{"R5 ", 3'd3, 1'b1, 1'b0, 16'h8000, 26'h0, 32'h0, 32'hBFC0044C, 32'hBFBE044C, 32'hBFBE0450, 1'b1, 32'hBFC00450, 1'b0, 1'b0},
    // R7 direct jump with link
    '{"R7 ", 3'd4, 1'b1, 1'b0, 16'h0000, 26'h0123456, 32'h0, 32'hBFBE044C, 32'hB048D158, 32'hB048D15C, 1'b1, 32'hBFBE0450, 1'b0, 1'b0},
    // R9 misaligned register jump with link
    '{"R9 ", 3'd5, 1'b1, 1'b0, 16'h0000, 26'h0, 32'h00001001, 32'hBFBE044C, 32'hB048D158, 32'hB048D15C, 1'b0, 32'h0, 1'b0, 1'b1},
    // R8 register jump
    '{"R8 ", 3'd5, 1'b0, 1'b0, 16'h0000, 26'h0, 32'h80000100, 32'hB048D158, 32'h80000100, 32'h80000104, 1'b0, 32'h0, 1'b0, 1'b0},
    // R10 likely not taken with link: annul and link together
    '{"R10", 3'd2, 1'b1, 1'b0, 16'h0040, 26'h0, 32'h0, 32'h80000104, 32'h80000108, 32'h8000010C, 1'b1, 32'h80000104, 1'b1, 1'b0},
    // R11 sequential kind ignores link
    '{"R11", 3'd0, 1'b1, 1'b1, 16'h0040, 26'h3, 32'h0, 32'h80000108, 32'h8000010C, 32'h80000110, 1'b0, 32'h0, 1'b0, 1'b0},
    // R11 reserved code acts sequential
    '{"R11", 3'd7, 1'b1, 1'b1, 16'h0040, 26'h3, 32'h4, 32'h8000010C, 32'h80000110, 32'h80000114, 1'b0, 32'h0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic [2:0]  kind_i = 3'd0;
  logic        link_i = 1'b0;
  logic        cond_i = 1'b0;
  logic [15:0] offset_i = '0;
  logic [25:0] index_i = '0;
  logic [31:0] reg_val_i = '0;
  logic [31:0] pc_o, npc_o, nnpc_o, link_data_o;
  logic        link_we_o, annul_o, misalign_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dslot_pc_seq u0 (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .kind_i(kind_i),
    .link_i(link_i), .cond_i(cond_i), .offset_i(offset_i),
    .index_i(index_i), .reg_val_i(reg_val_i), .pc_o(pc_o),
    .npc_o(npc_o), .nnpc_o(nnpc_o), .link_we_o(link_we_o),
    .link_data_o(link_data_o), .annul_o(annul_o), .misalign_o(misalign_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    kind_i = v.kind; link_i = v.link; cond_i = v.cond;
    offset_i = v.off; index_i = v.idx; reg_val_i = v.rv;
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic judge(input vec_t v, input string tag);
    chk(tag, "pc", pc_o, v.e_pc);
    chk(tag, "npc", npc_o, v.e_npc);
    chk(tag, "nnpc", nnpc_o, v.e_nnpc);
    chk(tag, "link_we", 32'(link_we_o), 32'(v.e_lwe));
    if (v.e_lwe) chk(tag, "link_data", link_data_o, v.e_ldata);
    chk(tag, "annul", 32'(annul_o), 32'(v.e_ann));
    chk(tag, "misalign", 32'(misalign_o), 32'(v.e_mis));
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    // R1 values held in reset
    chk("R1", "pc", pc_o, 32'hBFC00000);
    chk("R1", "npc", npc_o, 32'hBFC00004);
    chk("R1", "nnpc", nnpc_o, 32'hBFC00008);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pc after release", pc_o, 32'hBFC00000);
    chk("R1", "flags", {29'd0, link_we_o, annul_o, misalign_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      judge(VECS[i], $sformatf("%s", VECS[i].req));
    end

    // R10 link pulse lasts one cycle
    @(negedge clk);
    d = VECS[2];
    apply(d);
    chk("R10", "link pulse", 32'(link_we_o), 32'd1);
    @(negedge clk);
    chk("R10", "link pulse end", 32'(link_we_o), 32'd0);

    // R1 mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pc after rerun reset", pc_o, 32'hBFC00000);
    chk("R1", "annul after reset", 32'(annul_o), 32'd0);

    // R6 and R10 together from reset
    d = '{"R6 ", 3'd2, 1'b1, 1'b0, 16'h0010, 26'h0, 32'h0,
          32'hBFC00008, 32'hBFC0000C, 32'hBFC00010, 1'b1, 32'hBFC00008, 1'b1, 1'b0};
    apply(d);
    judge(d, "R6");

    // R2 idle cycles with noisy inputs: nothing moves, annul persists
    kind_i = 3'd5; reg_val_i = 32'h1234_5670; link_i = 1'b1; cond_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "idle pc", pc_o, 32'hBFC00008);
    chk("R2", "idle nnpc", nnpc_o, 32'hBFC00010);
    chk("R6", "annul held while idle", 32'(annul_o), 32'd1);
    chk("R2", "idle no link", 32'(link_we_o), 32'd0);

    // R6 annul drops on next advance
    d = '{"R6 ", 3'd0, 1'b0, 1'b0, 16'h0, 26'h0, 32'h0,
          32'hBFC0000C, 32'hBFC00010, 32'hBFC00014, 1'b0, 32'h0, 1'b0, 1'b0};
    apply(d);
    judge(d, "R6");

    // R8 register jump ignores a low condition, misalign pulse cleared
    d = '{"R8 ", 3'd5, 1'b0, 1'b0, 16'h0, 26'h0, 32'h0000_0800,
          32'hBFC00010, 32'h00000800, 32'h00000804, 1'b0, 32'h0, 1'b0, 1'b0};
    apply(d);
    judge(d, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule